// File: doc/BRIEF.md
# Masked Register Write Commit Unit with Status-Flag Arbitration

This block collects the masked register writes produced while one instruction bundle executes, up to two sub-instructions' worth. On a commit strobe it applies all of them in queue order within one clock edge. Each write names a target (a general register, the status word or the active stack pointer), a 32-bit value and a 32-bit bit mask. Only the masked bits of the target change.

Writes to the status word are arbitrated when they are applied. The memory-side sub-instruction is queued first and the integer-side sub-instruction is queued later. When a later status write touches some of the same condition flags as an earlier one, the later write wins those flags. If the later write also touches the overflow flag, the earlier write's accumulated-overflow bit is dropped as well. This arbitration is turned off when the memory-side instruction was a move to a system register.

After the writes, a trap request on the same commit saves the status word into a backup or a debug copy and then clears it. Finally, if the status word was written or a trap was taken, the stack-mode bit selects one of two banked stack pointers. The outgoing value is saved in its bank and the incoming one is restored.

Top module: `wcu_commit_unit`

## Requirements
- R1: A committed write to general register `t` (target code 0..3) sets that register to `(old & ~mask) | (value & mask)`. Without a commit, no register, status or stack value changes.
- R2: Queued writes are applied in the order they were queued, so a later write to the same bits wins. After a commit, `queue_count` is 0, or 1 when `enq_valid` was high in the commit cycle; that write is held for the next commit.
- R3: The queue holds 4 writes. An enqueue into a full queue is dropped and sets `overflow`, which stays set until reset.
- R4: The status word is target code 4. Big-endian bit numbering is used, so bit k is value `32'h8000_0000 >> k`. The contended flags are F0=17, F1=19, F2=21, F3=23, S=25, V=27, VA=29 and C=31. Take an earlier status write and a later one whose masks share a contended flag. The shared flags are removed from the earlier write's effective mask, and the earlier write's other bits (including VA when the later mask lacks V) still apply.
- R5: Under the same overlap condition, if the later mask includes V, the earlier write's VA bit is not applied, even though the later mask lacks VA.
- R6: When the two status masks share no contended flag, no bit of the earlier write is removed (an earlier VA-only write survives a later V-only write).
- R7: When `sys_move` is high at commit, no status bits are removed by arbitration.
- R8: Ordinary trap (`trap_kind`=1 with `commit`): `backup_status` takes the status word after the writes, and the status word keeps only DB (bit 3) and SM (bit 0).
- R9: Debug trap (`trap_kind`=2 with `commit`): `debug_status` takes the status word after the writes, and the status word becomes exactly DS (bit 4) set.
- R10: `stack_sel` always equals the SM bit of the status word. When SM changes at a commit, `stack_ptr` is saved into the old bank and reloaded from the new bank. Debug trap entry clears SM and so swaps too. Target code 5 writes `stack_ptr`.
- R11: A commit that leaves SM unchanged, including an ordinary trap, leaves `stack_ptr` unchanged.
- R12: After reset every register, copy, bank, counter and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Queue one write this cycle |
| enq_target | input | 3 | Target: 0..3 general, 4 status, 5 stack pointer |
| enq_value | input | 32 | Write data |
| enq_mask | input | 32 | Bits to change |
| commit | input | 1 | Apply the queue at this edge |
| sys_move | input | 1 | Memory-side instruction was a system-register move (no arbitration) |
| trap_kind | input | 2 | 0 none, 1 ordinary trap, 2 debug trap; used with commit |
| rd_sel | input | 2 | General register read select |
| rd_data | output | 32 | Selected general register |
| status_word | output | 32 | Current status word |
| backup_status | output | 32 | Status saved on ordinary trap |
| debug_status | output | 32 | Status saved on debug trap |
| stack_ptr | output | 32 | Active stack pointer |
| stack_sel | output | 1 | Active stack bank |
| queue_count | output | 3 | Writes waiting |
| overflow | output | 1 | Sticky queue overflow |

## Verification
Flag arbitration is visible at the ports only through the accumulated-overflow bit. Every flag the later write takes from the earlier one is rewritten by the later write anyway. Each arbitration scenario therefore queues two status writes in one bundle, where the earlier sets VA and the later touches V, C or nothing in common. The scenario then reads the status word after the commit, once with `sys_move` low and once high. The bank swap is observed by swapping away and back, because a saved bank shows up only when it is reloaded into `stack_ptr`.

// File: rtl/wcu_pkg.sv
package wcu_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned NGPR   = 4;
    parameter int unsigned DEPTH  = 4;

    localparam int unsigned TGT_W = $clog2(NGPR + 2);
    localparam int unsigned GPR_W = $clog2(NGPR);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    localparam logic [TGT_W-1:0] TGT_STATUS = TGT_W'(NGPR);
    localparam logic [TGT_W-1:0] TGT_SP     = TGT_W'(NGPR + 1);

    typedef struct packed {
        logic [TGT_W-1:0]  tgt;
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] mask;
    } wr_entry_t;

    typedef enum logic [1:0] {
        TRAP_NONE = 2'd0,
        TRAP_ORD  = 2'd1,
        TRAP_DBG  = 2'd2
    } trap_e;

    // big-endian numbering: position 0 is the MSB
    function automatic logic [DATA_W-1:0] be_bit(input int unsigned pos);
        logic [DATA_W-1:0] r;
        r = '0;
        r[DATA_W-1-pos] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/wcu_queue.sv
module wcu_queue
    import wcu_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  wr_entry_t                   entry,
    input  logic                        drain,
    output wr_entry_t [DEPTH-1:0]       entries,
    output logic [CNT_W-1:0]            count,
    output logic                        ovf
);

    typedef struct packed {
        wr_entry_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]      cnt;
        logic                  ovf;
    } q_state_t;

    q_state_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (drain) begin
            // queue empties; a same-cycle push becomes the first entry
            q_d.cnt = push ? CNT_W'(1) : '0;
            if (push) begin
                q_d.ent[0] = entry;
            end
        end else if (push) begin
            if (q_q.cnt < CNT_W'(DEPTH)) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (CNT_W'(k) == q_q.cnt) begin
                        q_d.ent[k] = entry;
                    end
                end
                q_d.cnt = q_q.cnt + CNT_W'(1);
            end else begin
                q_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign entries = q_q.ent;
    assign count   = q_q.cnt;
    assign ovf     = q_q.ovf;

endmodule

// File: rtl/wcu_merge.sv
module wcu_merge
    import wcu_pkg::*;
#(
    parameter int unsigned P_F0 = 17,
    parameter int unsigned P_F1 = 19,
    parameter int unsigned P_F2 = 21,
    parameter int unsigned P_F3 = 23,
    parameter int unsigned P_S  = 25,
    parameter int unsigned P_V  = 27,
    parameter int unsigned P_VA = 29,
    parameter int unsigned P_C  = 31
) (
    input  wr_entry_t [DEPTH-1:0]          entries,
    input  logic [CNT_W-1:0]               count,
    input  logic                           no_arb,
    input  logic [NGPR-1:0][DATA_W-1:0]    gpr_in,
    input  logic [DATA_W-1:0]              status_in,
    input  logic [DATA_W-1:0]              sp_in,
    output logic [NGPR-1:0][DATA_W-1:0]    gpr_out,
    output logic [DATA_W-1:0]              status_out,
    output logic [DATA_W-1:0]              sp_out,
    output logic                           status_hit
);

    localparam logic [DATA_W-1:0] FLAGS = be_bit(P_F0) | be_bit(P_F1) |
                                          be_bit(P_F2) | be_bit(P_F3) |
                                          be_bit(P_S)  | be_bit(P_V)  |
                                          be_bit(P_VA) | be_bit(P_C);
    localparam logic [DATA_W-1:0] MASK_V  = be_bit(P_V);
    localparam logic [DATA_W-1:0] MASK_VA = be_bit(P_VA);

    // effective mask of each entry after arbitration against later entries
    logic [DEPTH-1:0][DATA_W-1:0] eff;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            eff[i] = entries[i].mask;
            if (entries[i].tgt == TGT_STATUS && !no_arb) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j > i && CNT_W'(j) < count &&
                        entries[j].tgt == TGT_STATUS &&
                        (entries[j].mask & entries[i].mask & FLAGS) != '0) begin
                        eff[i] = eff[i] & ~(entries[j].mask & FLAGS);
                        if ((entries[j].mask & MASK_V) != '0) begin
                            eff[i] = eff[i] & ~MASK_VA;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        gpr_out    = gpr_in;
        status_out = status_in;
        sp_out     = sp_in;
        status_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < count) begin
                if (entries[i].tgt < TGT_STATUS) begin
                    gpr_out[entries[i].tgt[GPR_W-1:0]] =
                        (gpr_out[entries[i].tgt[GPR_W-1:0]] & ~eff[i]) |
                        (entries[i].val & eff[i]);
                end else if (entries[i].tgt == TGT_STATUS) begin
                    status_out = (status_out & ~eff[i]) | (entries[i].val & eff[i]);
                    status_hit = 1'b1;
                end else if (entries[i].tgt == TGT_SP) begin
                    sp_out = (sp_out & ~eff[i]) | (entries[i].val & eff[i]);
                end
            end
        end
    end

endmodule

// File: rtl/wcu_trap_bank.sv
module wcu_trap_bank
    import wcu_pkg::*;
#(
    parameter int unsigned P_SM = 0,
    parameter int unsigned P_DB = 3,
    parameter int unsigned P_DS = 4
) (
    input  logic [DATA_W-1:0]           status_in,
    input  logic                        status_hit,
    input  trap_e                       trap,
    input  logic [DATA_W-1:0]           sp_in,
    input  logic                        sel_in,
    input  logic [1:0][DATA_W-1:0]      bank_in,
    output logic [DATA_W-1:0]           status_out,
    output logic                        save_bkp,
    output logic                        save_dbg,
    output logic [DATA_W-1:0]           sp_out,
    output logic                        sel_out,
    output logic [1:0][DATA_W-1:0]      bank_out
);

    localparam logic [DATA_W-1:0] KEEP_ORD = be_bit(P_DB) | be_bit(P_SM);
    localparam logic [DATA_W-1:0] DBG_VAL  = be_bit(P_DS);
    localparam int unsigned       SM_IDX   = DATA_W - 1 - P_SM;

    logic new_sel;
    logic check;

    always_comb begin
        status_out = status_in;
        save_bkp   = 1'b0;
        save_dbg   = 1'b0;
        unique case (trap)
            TRAP_ORD: begin
                save_bkp   = 1'b1;
                status_out = status_in & KEEP_ORD;
            end
            TRAP_DBG: begin
                save_dbg   = 1'b1;
                status_out = DBG_VAL;
            end
            default: ;
        endcase

        check    = status_hit || (trap != TRAP_NONE);
        new_sel  = status_out[SM_IDX];
        sp_out   = sp_in;
        sel_out  = sel_in;
        bank_out = bank_in;
        if (check && new_sel != sel_in) begin
            bank_out[sel_in] = sp_in;
            sp_out           = bank_in[new_sel];
            sel_out          = new_sel;
        end
    end

endmodule

// File: rtl/wcu_commit_unit.sv
module wcu_commit_unit
    import wcu_pkg::*;
#(
    parameter int unsigned P_SM = 0,
    parameter int unsigned P_DB = 3,
    parameter int unsigned P_DS = 4,
    parameter int unsigned P_F0 = 17,
    parameter int unsigned P_F1 = 19,
    parameter int unsigned P_F2 = 21,
    parameter int unsigned P_F3 = 23,
    parameter int unsigned P_S  = 25,
    parameter int unsigned P_V  = 27,
    parameter int unsigned P_VA = 29,
    parameter int unsigned P_C  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [2:0]        enq_target,
    input  logic [31:0]       enq_value,
    input  logic [31:0]       enq_mask,
    input  logic              commit,
    input  logic              sys_move,
    input  logic [1:0]        trap_kind,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    output logic [31:0]       status_word,
    output logic [31:0]       backup_status,
    output logic [31:0]       debug_status,
    output logic [31:0]       stack_ptr,
    output logic              stack_sel,
    output logic [2:0]        queue_count,
    output logic              overflow
);

    typedef struct packed {
        logic [NGPR-1:0][DATA_W-1:0] gpr;
        logic [DATA_W-1:0]           status;
        logic [DATA_W-1:0]           bkp;
        logic [DATA_W-1:0]           dbg;
        logic [DATA_W-1:0]           sp;
        logic                        sel;
        logic [1:0][DATA_W-1:0]      bank;
    } arch_t;

    arch_t st_d, st_q;

    wr_entry_t                   new_entry;
    wr_entry_t [DEPTH-1:0]       q_entries;
    logic [CNT_W-1:0]            q_count;
    logic                        q_ovf;

    logic [NGPR-1:0][DATA_W-1:0] m_gpr;
    logic [DATA_W-1:0]           m_status;
    logic [DATA_W-1:0]           m_sp;
    logic                        m_hit;

    logic [DATA_W-1:0]           t_status;
    logic                        t_bkp;
    logic                        t_dbg;
    logic [DATA_W-1:0]           t_sp;
    logic                        t_sel;
    logic [1:0][DATA_W-1:0]      t_bank;
    trap_e                       trap_sel;

    assign new_entry.tgt  = enq_target;
    assign new_entry.val  = enq_value;
    assign new_entry.mask = enq_mask;

    always_comb begin
        unique case (trap_kind)
            2'd1:    trap_sel = TRAP_ORD;
            2'd2:    trap_sel = TRAP_DBG;
            default: trap_sel = TRAP_NONE;
        endcase
    end

    wcu_queue i_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (enq_valid),
        .entry   (new_entry),
        .drain   (commit),
        .entries (q_entries),
        .count   (q_count),
        .ovf     (q_ovf)
    );

    wcu_merge #(
        .P_F0(P_F0), .P_F1(P_F1), .P_F2(P_F2), .P_F3(P_F3),
        .P_S (P_S),  .P_V (P_V),  .P_VA(P_VA), .P_C (P_C)
    ) i_merge (
        .entries    (q_entries),
        .count      (q_count),
        .no_arb     (sys_move),
        .gpr_in     (st_q.gpr),
        .status_in  (st_q.status),
        .sp_in      (st_q.sp),
        .gpr_out    (m_gpr),
        .status_out (m_status),
        .sp_out     (m_sp),
        .status_hit (m_hit)
    );

    wcu_trap_bank #(
        .P_SM(P_SM), .P_DB(P_DB), .P_DS(P_DS)
    ) i_trap_bank (
        .status_in  (m_status),
        .status_hit (m_hit),
        .trap       (trap_sel),
        .sp_in      (m_sp),
        .sel_in     (st_q.sel),
        .bank_in    (st_q.bank),
        .status_out (t_status),
        .save_bkp   (t_bkp),
        .save_dbg   (t_dbg),
        .sp_out     (t_sp),
        .sel_out    (t_sel),
        .bank_out   (t_bank)
    );

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.gpr    = m_gpr;
            st_d.status = t_status;
            st_d.sp     = t_sp;
            st_d.sel    = t_sel;
            st_d.bank   = t_bank;
            if (t_bkp) begin
                st_d.bkp = m_status;
            end
            if (t_dbg) begin
                st_d.dbg = m_status;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data       = st_q.gpr[rd_sel];
    assign status_word   = st_q.status;
    assign backup_status = st_q.bkp;
    assign debug_status  = st_q.dbg;
    assign stack_ptr     = st_q.sp;
    assign stack_sel     = st_q.sel;
    assign queue_count   = q_count;
    assign overflow      = q_ovf;

endmodule

// File: rtl/wcu_checker.sv
module wcu_checker
    import wcu_pkg::*;
#(
    parameter int unsigned P_SM = 0,
    parameter int unsigned P_DB = 3,
    parameter int unsigned P_DS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enq_valid,
    input logic        commit,
    input logic [1:0]  trap_kind,
    input logic [31:0] status_word,
    input logic [31:0] stack_ptr,
    input logic        stack_sel,
    input logic [2:0]  queue_count,
    input logic        overflow
);

    localparam logic [31:0] KEEP = be_bit(P_DB) | be_bit(P_SM);
    localparam logic [31:0] DSV  = be_bit(P_DS);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        queue_count <= 3'(DEPTH));

    assert_no_overflow_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (queue_count == 3'($past(enq_valid))));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(status_word) && $stable(stack_ptr) && $stable(stack_sel)));

    assert_trap_ord_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && trap_kind == 2'd1) |=> ((status_word & ~KEEP) == 32'd0));

    assert_trap_dbg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && trap_kind == 2'd2) |=> (status_word == DSV));

    assert_bank_follows_sm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stack_sel == status_word[31-P_SM]);

endmodule

bind wcu_commit_unit wcu_checker #(
    .P_SM(P_SM), .P_DB(P_DB), .P_DS(P_DS)
) i_wcu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid   (enq_valid),
    .commit      (commit),
    .trap_kind   (trap_kind),
    .status_word (status_word),
    .stack_ptr   (stack_ptr),
    .stack_sel   (stack_sel),
    .queue_count (queue_count),
    .overflow    (overflow)
);

// File: tb/test_wcu_commit_unit.sv
module test_wcu_commit_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [2:0]  enq_target = '0;
    logic [31:0] enq_value = '0;
    logic [31:0] enq_mask = '0;
    logic        commit = 1'b0;
    logic        sys_move = 1'b0;
    logic [1:0]  trap_kind = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [31:0] status_word;
    logic [31:0] backup_status;
    logic [31:0] debug_status;
    logic [31:0] stack_ptr;
    logic        stack_sel;
    logic [2:0]  queue_count;
    logic        overflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [2:0]  T_ST = 3'd4;
    localparam logic [2:0]  T_SP = 3'd5;
    localparam logic [31:0] FULL = 32'hFFFF_FFFF;

    function automatic logic [31:0] bb(input int k);
        return 32'h8000_0000 >> k;
    endfunction

    wcu_commit_unit i_wcu_commit_unit (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_target(enq_target),
        .enq_value(enq_value), .enq_mask(enq_mask), .commit(commit),
        .sys_move(sys_move), .trap_kind(trap_kind), .rd_sel(rd_sel),
        .rd_data(rd_data), .status_word(status_word), .backup_status(backup_status),
        .debug_status(debug_status), .stack_ptr(stack_ptr), .stack_sel(stack_sel),
        .queue_count(queue_count), .overflow(overflow)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock; inputs return to idle just after the edge, outputs are then settled
    task automatic step();
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
        commit    = 1'b0;
        sys_move  = 1'b0;
        trap_kind = 2'd0;
    endtask

    task automatic push(input logic [2:0] t, input logic [31:0] v, input logic [31:0] m);
        enq_valid  = 1'b1;
        enq_target = t;
        enq_value  = v;
        enq_mask   = m;
        step();
    endtask

    task automatic do_commit(input logic mv, input logic [1:0] tk);
        commit    = 1'b1;
        sys_move  = mv;
        trap_kind = tk;
        step();
    endtask

    task automatic clear_status();
        push(T_ST, 32'd0, FULL);
        do_commit(1'b0, 2'd0);
    endtask

    function automatic logic [31:0] rd(input logic [1:0] s);
        return i_rd_data_at(s);
    endfunction

    function automatic logic [31:0] i_rd_data_at(input logic [1:0] s);
        return (s == rd_sel) ? rd_data : 32'hx;
    endfunction

    task automatic t_reset();
        chk("R12 status", status_word, 32'd0);
        chk("R12 count", 32'(queue_count), 32'd0);
        chk("R12 overflow", 32'(overflow), 32'd0);
        chk("R12 sp", stack_ptr, 32'd0);
        chk("R12 sel", 32'(stack_sel), 32'd0);
        rd_sel = 2'd1;
        #1;
        chk("R12 gpr1", rd(2'd1), 32'd0);
    endtask

    task automatic t_merge();
        rd_sel = 2'd1;
        push(3'd1, FULL, 32'h0000_FF00);
        chk("R1 no change before commit", rd(2'd1), 32'd0);
        do_commit(1'b0, 2'd0);
        chk("R1 masked set", rd(2'd1), 32'h0000_FF00);
        push(3'd1, 32'd0, 32'h0000_0F00);
        do_commit(1'b0, 2'd0);
        chk("R1 masked clear", rd(2'd1), 32'h0000_F000);
    endtask

    task automatic t_order();
        rd_sel = 2'd2;
        push(3'd2, 32'hAAAA_AAAA, FULL);
        push(3'd2, 32'h5555_5555, 32'h0000_FFFF);
        chk("R2 count before commit", 32'(queue_count), 32'd2);
        do_commit(1'b0, 2'd0);
        chk("R2 later wins", rd(2'd2), 32'hAAAA_5555);
        chk("R2 count after commit", 32'(queue_count), 32'd0);
    endtask

    task automatic t_concurrent();
        rd_sel = 2'd0;
        push(3'd0, 32'h0000_00AA, 32'h0000_00FF);
        enq_valid  = 1'b1;
        enq_target = 3'd0;
        enq_value  = 32'h0000_BB00;
        enq_mask   = 32'h0000_FF00;
        do_commit(1'b0, 2'd0);
        chk("R2 held write count", 32'(queue_count), 32'd1);
        chk("R2 only old entry applied", rd(2'd0), 32'h0000_00AA);
        do_commit(1'b0, 2'd0);
        chk("R2 held write applied", rd(2'd0), 32'h0000_BBAA);
    endtask

    task automatic t_flag_overlap();
        clear_status();
        push(T_ST, bb(29) | bb(31), bb(29) | bb(31));
        push(T_ST, 32'd0, bb(31));
        do_commit(1'b0, 2'd0);
        chk("R4 overlap keeps VA", status_word, bb(29));
    endtask

    task automatic t_va_suppress();
        clear_status();
        push(T_ST, bb(29) | bb(17), bb(29) | bb(17));
        push(T_ST, 32'd0, bb(27) | bb(17));
        do_commit(1'b0, 2'd0);
        chk("R5 VA suppressed by later V", status_word, 32'd0);
    endtask

    task automatic t_no_overlap();
        clear_status();
        push(T_ST, bb(29), bb(29));
        push(T_ST, bb(27), bb(27));
        do_commit(1'b0, 2'd0);
        chk("R6 disjoint flags kept", status_word, bb(29) | bb(27));
    endtask

    task automatic t_sysmove();
        clear_status();
        push(T_ST, bb(29) | bb(17), bb(29) | bb(17));
        push(T_ST, 32'd0, bb(27) | bb(17));
        do_commit(1'b1, 2'd0);
        chk("R7 no arbitration", status_word, bb(29));
    endtask

    task automatic t_trap_ord();
        clear_status();
        push(T_ST, bb(3) | bb(5) | bb(17), FULL);
        do_commit(1'b0, 2'd1);
        chk("R8 backup", backup_status, bb(3) | bb(5) | bb(17));
        chk("R8 status kept bits", status_word, bb(3));
    endtask

    task automatic t_trap_dbg();
        clear_status();
        push(T_ST, bb(5) | bb(31), FULL);
        do_commit(1'b0, 2'd0);
        do_commit(1'b0, 2'd2);
        chk("R9 debug copy", debug_status, bb(5) | bb(31));
        chk("R9 status DS only", status_word, bb(4));
    endtask

    task automatic t_stack();
        clear_status();
        push(T_SP, 32'h1111_1111, FULL);
        do_commit(1'b0, 2'd0);
        chk("R10 sp write", stack_ptr, 32'h1111_1111);
        push(T_ST, bb(0), bb(0));
        do_commit(1'b0, 2'd0);
        chk("R10 sel to bank1", 32'(stack_sel), 32'd1);
        chk("R10 sp from bank1", stack_ptr, 32'd0);
        push(T_SP, 32'h2222_2222, FULL);
        do_commit(1'b0, 2'd0);
        push(T_ST, bb(5), bb(5));
        do_commit(1'b0, 2'd0);
        chk("R11 sm unchanged", stack_ptr, 32'h2222_2222);
        do_commit(1'b0, 2'd2);
        chk("R10 debug trap swaps", stack_ptr, 32'h1111_1111);
        chk("R10 debug trap sel", 32'(stack_sel), 32'd0);
        push(T_ST, bb(0), bb(0));
        do_commit(1'b0, 2'd0);
        chk("R10 bank1 restored", stack_ptr, 32'h2222_2222);
        do_commit(1'b0, 2'd1);
        chk("R11 ordinary trap keeps sp", stack_ptr, 32'h2222_2222);
        clear_status();
        chk("R10 bank0 restored", stack_ptr, 32'h1111_1111);
    endtask

    task automatic t_overflow();
        rd_sel = 2'd3;
        push(3'd3, 32'h0000_0001, 32'h0000_0001);
        push(3'd3, 32'h0000_0002, 32'h0000_0002);
        push(3'd3, 32'h0000_0004, 32'h0000_0004);
        push(3'd3, 32'h0000_0008, 32'h0000_0008);
        chk("R3 full no overflow", 32'(overflow), 32'd0);
        push(3'd3, FULL, FULL);
        chk("R3 overflow set", 32'(overflow), 32'd1);
        chk("R3 count capped", 32'(queue_count), 32'd4);
        do_commit(1'b0, 2'd0);
        chk("R3 dropped write", rd(2'd3), 32'h0000_000F);
        chk("R3 overflow sticky", 32'(overflow), 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_merge();
        t_order();
        t_concurrent();
        t_flag_overlap();
        t_va_suppress();
        t_no_overlap();
        t_sysmove();
        t_trap_ord();
        t_trap_dbg();
        t_stack();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule